// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration space of one endpoint or bridge function as sixty-four 32-bit registers. Identity values, the header kind, the base-address-register (BAR) layout and whether a capability list is present are fixed by parameters at elaboration. Reset loads the registers from these parameters. Software then writes through a byte, halfword or dword port that is addressed by byte offset. Reads return a whole register, selected by index.

Every register has a constant writable-bit mask that is derived from the same parameters. A write changes only the bits that both the mask and the access lanes allow. Bits outside the mask keep their reset value for good. Because of this, a BAR sizing probe that writes all ones reads back the size alignment of the region, with the region's fixed low bits kept.

BAR encoding parameters: `BAR_KIND` holds 2 bits per BAR (0 unused, 1 memory 32-bit, 2 memory 64-bit, 3 I/O). `BAR_LOG2` holds 6 bits per BAR and gives log2 of the region size. `BAR_PREF` holds 1 bit per BAR and marks a memory BAR as prefetchable. A 64-bit BAR uses the following register for its upper half, so that following BAR slot must be left unused.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, the identity registers read as follows. Register 0 is {device ID, vendor ID}, with the vendor ID in bits 15:0. Register 2 is {class, subclass, programming interface, 8'h00}, with the class in bits 31:24. Register 11 is {subsystem ID, subsystem vendor ID}, with the subsystem vendor ID in bits 15:0. No write changes any of them.
- R2: In register 1, bits 15:0 (command) are writable and bits 31:16 (status) are read-only. In register 3, only bits 7:0 (cache line size) are writable.
- R3: With a device header, register 3 bits 23:16 read 0x00 and register 15 has writable mask 0x000000FF. With a bridge header, register 3 resets to 0x00010000, register 9 has mask 0xFFF0FFF0 unless a BAR occupies it, and register 15 has mask 0xFFFF00FF.
- R4: A used BAR register at index 4+n has writable mask ~(size-1). Writing 0xFFFFFFFF to it therefore reads back the size alignment. An unused BAR slot reads 0 and cannot be written.
- R5: The low bits of a BAR are fixed. A memory BAR reads bit 0 = 0, bits 2:1 = 2'b00 for 32-bit or 2'b10 for 64-bit, and bit 3 = prefetchable. An I/O BAR reads bit 0 = 1 and bit 1 = 0. The upper register of a 64-bit BAR has mask ~((size>>32)-1), truncated to 32 bits, which makes it read-only when size < 2^32.
- R6: The write size code is 0 for a byte, 1 for a halfword, 2 for a dword and 3 for no access. Write data is right-aligned in wr_data. A byte write is accepted at any offset. A halfword write is accepted only at offset%4 of 0 or 2. A dword write is accepted only at offset%4 = 0. Any other write is dropped.
- R7: A read of an index of 64 or more returns 0xFFFFFFFF. A write at a byte offset of 256 or more changes no register.
- R8: When a capability is present, register 1 bit 20 reads 1, register 13 bits 7:0 read 0x40, and register 16 reads {16'h0, next pointer 8'h00, capability ID}.
- R9: rd_data is loaded on the clock edge at which rd_en is high, and it holds its value otherwise. A write in the same cycle as a read of that register is not visible in that read. The write is visible to the next read.
- R10: A synchronous active-high reset restores every register to its parameter-derived value and clears rd_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_off | input | OFFW | Byte offset of the write |
| wr_size | input | 2 | Write size code (byte, halfword, dword, none) |
| wr_data | input | 32 | Write data, right-aligned |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | IDXW | Register index to read |
| rd_data | output | 32 | Registered read data |

## Verification
Two instances are exercised side by side. One has a device header, a capability, and a 32-bit memory BAR, a prefetchable 64-bit memory BAR and an I/O BAR. The other has a bridge header with no BARs. All-ones probes of each BAR slot distinguish a correct size mask from a mask that is shifted or that leaks into the fixed type bits. Byte, halfword and dword writes at every lane alignment show whether the drop rules for unaligned accesses and the read-only status half are applied. Out-of-range indices and offsets, including an offset that would alias register 0 if it were truncated, show whether the range checks are made on the full width. A write and a read of the same register in one cycle tells the registered read of the old value apart from a bypass of the new one.

// File: rtl/cfg_space_regs.sv
module cfg_space_regs #(
  parameter int          OFFW       = 10,
  parameter int          IDXW       = 8,
  parameter logic [15:0] VEN_ID     = 16'h1AB0,
  parameter logic [15:0] DEV_ID     = 16'h7C21,
  parameter logic [7:0]  CLASS_C    = 8'h04,
  parameter logic [7:0]  SUBCLASS_C = 8'h01,
  parameter logic [7:0]  PROG_IF    = 8'h5A,
  parameter logic [15:0] SUB_VEN_ID = 16'h3E11,
  parameter logic [15:0] SUB_ID     = 16'h0042,
  parameter bit          IS_BRIDGE  = 1'b0,
  parameter bit          HAS_CAP    = 1'b1,
  parameter logic [7:0]  CAP_ID     = 8'h09,
  parameter logic [11:0] BAR_KIND   = 12'b00_00_11_00_10_01,
  parameter logic [35:0] BAR_LOG2   = {6'd0, 6'd0, 6'd5, 6'd0, 6'd20, 6'd12},
  parameter logic [5:0]  BAR_PREF   = 6'b000010
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [OFFW-1:0] wr_off,
  input  logic [1:0]      wr_size,
  input  logic [31:0]     wr_data,
  input  logic            rd_en,
  input  logic [IDXW-1:0] rd_idx,
  output logic [31:0]     rd_data
);
  localparam int NREG    = 64;
  localparam int NBAR    = 6;
  localparam int BAR0    = 4;
  localparam int CAP_OFS = 'h40;
  typedef logic [NREG-1:0][31:0] tbl_t;

  function automatic tbl_t build_init();
    tbl_t t = '0;
    t[0]  = {DEV_ID, VEN_ID};
    t[1]  = HAS_CAP ? 32'h0010_0000 : 32'h0;
    t[2]  = {CLASS_C, SUBCLASS_C, PROG_IF, 8'h00};
    t[3]  = IS_BRIDGE ? 32'h0001_0000 : 32'h0;
    t[11] = {SUB_ID, SUB_VEN_ID};
    if (HAS_CAP) begin
      t[13] = 32'(CAP_OFS);
      t[CAP_OFS/4] = {24'h0, CAP_ID};
    end
    for (int i = 0; i < NBAR; i++)
      case (BAR_KIND[2*i +: 2])
        2'd1: t[BAR0+i] = {28'h0, BAR_PREF[i], 3'b000};
        2'd2: t[BAR0+i] = {28'h0, BAR_PREF[i], 3'b100};
        2'd3: t[BAR0+i] = 32'h1;
        default: ;
      endcase
    return t;
  endfunction

  function automatic tbl_t build_mask();
    tbl_t t = '0;
    logic [63:0] sz, hi;
    t[1]  = 32'h0000_FFFF;
    t[3]  = 32'h0000_00FF;
    t[15] = IS_BRIDGE ? 32'hFFFF_00FF : 32'h0000_00FF;
    if (IS_BRIDGE) t[9] = 32'hFFF0_FFF0;
    for (int i = 0; i < NBAR; i++) begin
      sz = 64'd1 << BAR_LOG2[6*i +: 6];
      hi = ~((sz >> 32) - 64'd1);
      case (BAR_KIND[2*i +: 2])
        2'd1: t[BAR0+i] = ~sz[31:0] + 32'd1 & 32'hFFFF_FFF0;
        2'd2: begin
          t[BAR0+i] = ~sz[31:0] + 32'd1 & 32'hFFFF_FFF0;
          if (i < NBAR-1) t[BAR0+i+1] = hi[31:0];
        end
        2'd3: t[BAR0+i] = ~sz[31:0] + 32'd1 & 32'hFFFF_FFFC;
        default: ;
      endcase
    end
    return t;
  endfunction

  localparam tbl_t INIT = build_init();
  localparam tbl_t MASK = build_mask();

  tbl_t        regs;
  logic [31:0] lane_m, wmask, wshift;
  logic [5:0]  wr_idx;
  logic        in_rng;

  assign wr_idx = wr_off[7:2];
  assign in_rng = (wr_off[OFFW-1:8] == '0);
  assign wshift = wr_data << {wr_off[1:0], 3'b000};
  assign wmask  = lane_m & MASK[wr_idx];

  always_comb begin
    case (wr_size)
      2'd0:    lane_m = 32'h0000_00FF << {wr_off[1:0], 3'b000};
      2'd1:    lane_m = wr_off[0] ? 32'h0 : 32'h0000_FFFF << {wr_off[1:0], 3'b000};
      2'd2:    lane_m = (wr_off[1:0] == 2'b00) ? 32'hFFFF_FFFF : 32'h0;
      default: lane_m = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) regs <= INIT;
    else if (wr_en && in_rng)
      regs[wr_idx] <= (regs[wr_idx] & ~wmask) | (wshift & wmask);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en)
      rd_data <= (rd_idx < IDXW'(NREG)) ? regs[rd_idx[5:0]] : 32'hFFFF_FFFF;
  end

  // R7
  oor_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_idx >= IDXW'(NREG) |=> rd_data == 32'hFFFF_FFFF);
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  // R1
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_idx == '0 |=> rd_data == {DEV_ID, VEN_ID});
  // R6
  odd_half_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_size == 2'd1 && wr_off[0] |=> $stable(regs));

  for (genvar g = 0; g < NBAR; g++) begin : g_bar_chk
    if (BAR_KIND[2*g +: 2] != 2'd0) begin : g_used
      // R5
      bar_type_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_idx == IDXW'(BAR0+g) |=> rd_data[3:0] == INIT[BAR0+g][3:0]);
    end
  end
endmodule

// File: tb/cfg_space_regs_tb_top.sv
module cfg_space_regs_tb_top;
  logic        clk = 0, rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [9:0]  wr_off = 0;
  logic [1:0]  wr_size = 0;
  logic [31:0] wr_data = 0;
  logic [7:0]  rd_idx = 0;
  logic [31:0] rd_a, rd_b;
  int checks = 0, errors = 0;
  string cur = "R10";
  bit started = 0, done = 0;

  always #5 clk = ~clk;

  cfg_space_regs dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off),
    .wr_size(wr_size), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_a));

  cfg_space_regs #(.IS_BRIDGE(1'b1), .HAS_CAP(1'b0), .BAR_KIND(12'h0), .BAR_LOG2(36'h0),
    .BAR_PREF(6'h0)) dut_b (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off),
    .wr_size(wr_size), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_b));

  logic [31:0] ia [64], ka [64], ib [64], kb [64];
  logic [31:0] ma [64], mb [64];
  logic [31:0] ea, eb;

  initial begin
    for (int i = 0; i < 64; i++) begin ia[i] = 0; ka[i] = 0; ib[i] = 0; kb[i] = 0; end
    ia[0] = 32'h7C21_1AB0; ia[1] = 32'h0010_0000; ia[2] = 32'h0401_5A00;
    ia[5] = 32'h0000_000C; ia[7] = 32'h1; ia[11] = 32'h0042_3E11;
    ia[13] = 32'h40; ia[16] = 32'h09;
    ka[1] = 32'hFFFF; ka[3] = 32'hFF; ka[4] = 32'hFFFF_F000; ka[5] = 32'hFFF0_0000;
    ka[7] = 32'hFFFF_FFE0; ka[15] = 32'hFF;
    ib[0] = ia[0]; ib[2] = ia[2]; ib[3] = 32'h0001_0000; ib[11] = ia[11];
    kb[1] = 32'hFFFF; kb[3] = 32'hFF; kb[9] = 32'hFFF0_FFF0; kb[15] = 32'hFFFF_00FF;
  end

  // reference model, byte by byte from the access rules
  always @(posedge clk) begin
    int lane, idx;
    bit take;
    started <= 1;
    if (rst) begin
      ma <= ia; mb <= ib; ea <= 0; eb <= 0;
    end else begin
      if (rd_en) begin
        ea <= (rd_idx < 64) ? ma[rd_idx] : 32'hFFFF_FFFF;
        eb <= (rd_idx < 64) ? mb[rd_idx] : 32'hFFFF_FFFF;
      end
      if (wr_en && wr_off < 256) begin
        lane = wr_off % 4; idx = wr_off / 4;
        for (int b = 0; b < 4; b++) begin
          case (wr_size)
            2'd0: take = (b == lane);
            2'd1: take = (lane == 0 || lane == 2) && (b == lane || b == lane + 1);
            2'd2: take = (lane == 0);
            default: take = 0;
          endcase
          if (take) begin
            ma[idx][8*b +: 8] <= (ma[idx][8*b +: 8] & ~ka[idx][8*b +: 8]) |
                                 (wr_data[8*(b-lane) +: 8] & ka[idx][8*b +: 8]);
            mb[idx][8*b +: 8] <= (mb[idx][8*b +: 8] & ~kb[idx][8*b +: 8]) |
                                 (wr_data[8*(b-lane) +: 8] & kb[idx][8*b +: 8]);
          end
        end
      end
    end
  end

  always @(negedge clk) if (started && !done) begin
    checks += 2;
    if (rd_a !== ea) begin errors++; $display("FAIL %s model dev: got %h exp %h", cur, rd_a, ea); end
    if (rd_b !== eb) begin errors++; $display("FAIL %s model bridge: got %h exp %h", cur, rd_b, eb); end
  end

  task automatic wr(input int off, input int sz, input logic [31:0] d);
    wr_en = 1; wr_off = 10'(off); wr_size = 2'(sz); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int idx, input logic [31:0] xa, input bit cb, input logic [31:0] xb,
                    input string tag);
    rd_en = 1; rd_idx = 8'(idx);
    @(negedge clk); rd_en = 0;
    checks++;
    if (rd_a !== xa) begin errors++; $display("FAIL %s dev reg %0d: got %h exp %h", tag, idx, rd_a, xa); end
    if (cb) begin
      checks++;
      if (rd_b !== xb) begin errors++; $display("FAIL %s bridge reg %0d: got %h exp %h", tag, idx, rd_b, xb); end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    done = 1; errors++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rd_a !== 0) begin errors++; $display("FAIL R10 reset rd_data: got %h exp 0", rd_a); end
    rst = 0;
    cur = "R1";
    rd(0, 32'h7C21_1AB0, 1, 32'h7C21_1AB0, "R1");
    rd(2, 32'h0401_5A00, 1, 32'h0401_5A00, "R1");
    rd(11, 32'h0042_3E11, 1, 32'h0042_3E11, "R1");
    wr(0, 2, 32'hFFFF_FFFF);
    rd(0, 32'h7C21_1AB0, 1, 32'h7C21_1AB0, "R1");
    cur = "R8";
    rd(1, 32'h0010_0000, 1, 32'h0, "R8");
    rd(13, 32'h40, 1, 32'h0, "R8");
    rd(16, 32'h09, 0, 0, "R8");
    cur = "R2";
    wr(4, 2, 32'hFFFF_FFFF);
    rd(1, 32'h0010_FFFF, 1, 32'h0000_FFFF, "R2");
    wr(6, 1, 32'h0000_ABCD);
    rd(1, 32'h0010_FFFF, 1, 32'h0000_FFFF, "R2");
    wr(4, 0, 32'h12);
    rd(1, 32'h0010_FF12, 1, 32'h0000_FF12, "R2");
    cur = "R3";
    wr(12, 2, 32'hFFFF_FFFF);
    rd(3, 32'h0000_00FF, 1, 32'h0001_00FF, "R3");
    wr(60, 2, 32'hFFFF_FFFF);
    rd(15, 32'h0000_00FF, 1, 32'hFFFF_00FF, "R3");
    wr(36, 2, 32'hFFFF_FFFF);
    rd(9, 32'h0, 1, 32'hFFF0_FFF0, "R3");
    cur = "R6";
    wr(5, 1, 32'h0);
    rd(1, 32'h0010_FF12, 0, 0, "R6");
    wr(5, 2, 32'h0);
    rd(1, 32'h0010_FF12, 0, 0, "R6");
    wr(4, 3, 32'h0);
    rd(1, 32'h0010_FF12, 0, 0, "R6");
    wr(5, 0, 32'h00);
    rd(1, 32'h0010_0012, 0, 0, "R6");
    wr(62, 1, 32'h0000_5A5A);
    rd(15, 32'h0000_00FF, 1, 32'h5A5A_00FF, "R6");
    cur = "R4";
    for (int i = 16; i <= 32; i += 4) wr(i, 2, 32'hFFFF_FFFF);
    rd(4, 32'hFFFF_F000, 0, 0, "R4");
    rd(5, 32'hFFF0_000C, 0, 0, "R5");
    rd(6, 32'h0, 0, 0, "R5");
    rd(7, 32'hFFFF_FFE1, 0, 0, "R5");
    rd(8, 32'h0, 0, 0, "R4");
    wr(16, 2, 32'h1234_5678);
    rd(4, 32'h1234_5000, 0, 0, "R4");
    cur = "R7";
    rd(64, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, "R7");
    rd(255, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, "R7");
    wr(256 + 4, 2, 32'h0);
    rd(1, 32'h0010_0012, 0, 0, "R7");
    cur = "R9";
    wr_en = 1; wr_off = 10'd4; wr_size = 2'd0; wr_data = 32'h77; rd_en = 1; rd_idx = 8'd1;
    @(negedge clk); wr_en = 0; rd_en = 0;
    checks++;
    if (rd_a !== 32'h0010_0012) begin errors++; $display("FAIL R9 same-cycle read: got %h exp %h", rd_a, 32'h0010_0012); end
    repeat (3) @(negedge clk);
    checks++;
    if (rd_a !== 32'h0010_0012) begin errors++; $display("FAIL R9 hold: got %h exp %h", rd_a, 32'h0010_0012); end
    rd(1, 32'h0010_0077, 0, 0, "R9");
    cur = "R10";
    rst = 1; @(negedge clk); rst = 0;
    rd(4, 32'h0, 0, 0, "R10");
    rd(1, 32'h0010_0000, 1, 32'h0, "R10");
    rd(15, 32'h0, 1, 32'h0, "R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule